// File: doc/BRIEF.md
# Iterative 64-bit Integer Divider

This block is a multi-cycle radix-2 restoring divider meant to sit beside an integer execute stage. The issuing stage hands it two non-negative magnitudes, a dividend and a divisor, along with a set of control flags:

- **Negate the result.** The issuer has already turned any negative signed operand into its magnitude. It sets this flag when the final answer must be negative: the XOR of the operand signs for a quotient, or the dividend's sign alone for a remainder.
- **Signed range.** Selects signed range checking.
- **Extended numerator.** Places the dividend above a block of zero bits.
- **Remainder.** Returns the remainder instead of the quotient.
- **32-bit word.** Selects 32-bit operation.

The divider produces one shift-and-subtract step per cycle. It then applies range checking and sign correction in a final stage and presents a 64-bit result with a one-cycle valid pulse.

The operand side is a valid/ready handshake. `in_ready` is high whenever no division is in progress, and an operation is taken on a clock edge where both `in_valid` and `in_ready` are high. While a division runs, `in_ready` is low and any `in_valid` is ignored; the issuer must hold its request until `in_ready` returns. The result side has no back-pressure: `out_valid` is a single-cycle pulse and the consumer must take `out_result` in that cycle. A new operation may be accepted in the cycle before the previous result appears, so back-to-back operations overlap by one cycle.

A zero divisor, and any quotient that does not fit the selected signed or unsigned width, produce an all-zero result instead of a trap.

Top module: `idiv64`

## Requirements
- R1: After synchronous active-high reset, `out_valid` is 0, `out_result` is 0 and `in_ready` is 1.
- R2: An operation is accepted on an edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `in_ready` stays 0 until the division's steps are done. Any `in_valid` seen while `in_ready` is 0 is ignored, so the result and the timing of the running operation are unchanged.
- R3: `out_valid` rises exactly 65 clock edges after the accepting edge and stays high for exactly one cycle.
- R4: For an unsigned 64-bit quotient (signed=0, extended=0, remainder=0, word=0), the result is floor(dividend / divisor); for example, 0x10001000 / 0x1111 = 0xF001.
- R5: With negate=1, a quotient is returned as the two's complement of its magnitude. With signed=1 in 64-bit mode, a magnitude of at least 2^63 (with negate=0), or above 2^63 (with negate=1), gives 0.
- R6: In remainder mode, the result is (numerator mod divisor), two's-complemented when negate=1. No range check applies to it, except the one in R8.
- R7: A zero divisor (all 64 bits zero in 64-bit mode, or the low 32 bits zero in word mode) gives a result of 0 in every mode.
- R8: In 64-bit extended mode, the numerator is dividend * 2^64. If dividend >= divisor, the result is 0, in quotient and remainder mode alike. With signed=1, the signed 64-bit range of R5 also applies.
- R9: In word mode, only bits [31:0] of both operands are used. A quotient result always has bits [63:32] cleared. With signed=1, a quotient magnitude at or above 2^31 (negate=0), or above 2^31 (negate=1), gives 0.
- R10: In word extended mode, the numerator is dividend[31:0] * 2^32. With signed=0, a quotient of 2^32 or more gives 0.
- R11: In word remainder mode with negate=1, the 32-bit negative remainder appears sign-extended across all 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | High when a request can be accepted |
| in_dividend | input | 64 | Dividend magnitude |
| in_divisor | input | 64 | Divisor magnitude |
| in_negate | input | 1 | Two's-complement the final result |
| in_signed | input | 1 | Apply signed range limits to the quotient |
| in_extended | input | 1 | Shift the dividend up by the operand width |
| in_modulus | input | 1 | Return remainder instead of quotient |
| in_word | input | 1 | 32-bit operation |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 64 | Result, valid while out_valid is high |

## Verification
A wrong step count or a stuck busy state shows at the ports as `out_valid` arriving on a different edge than the 65th, or not at all. The bench flags this within about 70 cycles of each accepted operation. A corrupted partial remainder or quotient bit shows only at the pulse, as a wrong `out_result`. Random operands across all sixteen flag combinations, together with directed range-limit cases, expose it within one operation. A start that leaks through while busy shows as a changed result, or as a second pulse, in the same window.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  typedef struct packed {
    logic negate;
    logic sgn;
    logic ext;
    logic modulus;
    logic word;
  } idiv_flags_t;
endpackage

// File: rtl/idiv_ctrl.sv
module idiv_ctrl #(
  parameter int STEPS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic fin,
  output logic out_valid
);
  localparam int CW = $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic          busy_q, fin_q, vld_q;
  logic [CW-1:0] cnt_q;

  assign in_ready  = !busy_q;
  assign load      = in_valid && !busy_q;
  assign step      = busy_q;
  assign fin       = fin_q;
  assign out_valid = vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
      vld_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      vld_q <= fin_q;
      fin_q <= busy_q && (cnt_q == LAST);
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST) busy_q <= 1'b0;
        else               cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (busy_q && in_valid && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_FIN_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    fin_q |=> vld_q); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q); // R3
endmodule

// File: rtl/idiv_core.sv
module idiv_core
  import idiv_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          fin,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  input  idiv_flags_t   flags_in,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          dvs_zero,
  output logic          pre_ovf,
  output idiv_flags_t   flags_q
);
  localparam int HW = DW / 2;

  logic [DW:0]   rem_q;
  logic [DW-1:0] num_q, dvs_q;
  logic          zero_q, povf_q;
  idiv_flags_t   fl_q;

  logic [DW-1:0] num_init, rem_init, dvs_init;
  always_comb begin
    if (flags_in.word) begin
      dvs_init = {{HW{1'b0}}, divisor[HW-1:0]};
      rem_init = '0;
      num_init = flags_in.ext ? {dividend[HW-1:0], {HW{1'b0}}}
                              : {{HW{1'b0}}, dividend[HW-1:0]};
    end else begin
      dvs_init = divisor;
      rem_init = flags_in.ext ? dividend : '0;
      num_init = flags_in.ext ? '0 : dividend;
    end
  end

  logic [DW:0] r2, diff;
  logic        ge;
  always_comb begin
    r2   = {rem_q[DW-1:0], num_q[DW-1]};
    ge   = r2 >= {1'b0, dvs_q};
    diff = r2 - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (load) begin
      rem_q  <= {1'b0, rem_init};
      num_q  <= num_init;
      dvs_q  <= dvs_init;
      zero_q <= (dvs_init == '0);
      povf_q <= !flags_in.word && flags_in.ext && (dividend >= divisor);
      fl_q   <= flags_in;
    end else if (step) begin
      rem_q <= ge ? diff : r2;
      num_q <= {num_q[DW-2:0], ge};
    end
  end

  assign quo      = num_q;
  assign rem      = rem_q[DW-1:0];
  assign dvs_zero = zero_q;
  assign pre_ovf  = povf_q;
  assign flags_q  = fl_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (fin && !zero_q && !povf_q) |-> (rem_q < {1'b0, dvs_q})); // R6
endmodule

// File: rtl/idiv_fixup.sv
module idiv_fixup
  import idiv_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0] quo,
  input  logic [DW-1:0] rem,
  input  logic          dvs_zero,
  input  logic          pre_ovf,
  input  idiv_flags_t   flags,
  output logic [DW-1:0] result
);
  localparam int HW = DW / 2;
  localparam logic [DW-1:0] LIM_W = DW'(1) << (HW - 1);
  localparam logic [DW-1:0] LIM_D = DW'(1) << (DW - 1);

  logic          ovf;
  logic [DW-1:0] lim, base, signed_v;

  always_comb begin
    lim = flags.word ? LIM_W : LIM_D;
    if (flags.sgn)
      ovf = (quo > lim) || (quo == lim && !flags.negate);
    else
      ovf = flags.word && (quo[DW-1:HW] != '0);

    base     = flags.modulus ? rem : quo;
    signed_v = flags.negate ? (~base + 1'b1) : base;
    if (flags.word && !flags.modulus)
      signed_v[DW-1:HW] = '0;

    if (dvs_zero || pre_ovf || (ovf && !flags.modulus))
      result = '0;
    else
      result = signed_v;
  end
endmodule

// File: rtl/idiv64.sv
module idiv64
  import idiv_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_dividend,
  input  logic [DW-1:0] in_divisor,
  input  logic          in_negate,
  input  logic          in_signed,
  input  logic          in_extended,
  input  logic          in_modulus,
  input  logic          in_word,
  output logic          out_valid,
  output logic [DW-1:0] out_result
);
  localparam int HW = DW / 2;

  logic          load, step, fin;
  logic [DW-1:0] quo, rem, fix_res;
  logic          dvs_zero, pre_ovf;
  idiv_flags_t   flags_in, flags_q;
  logic [DW-1:0] res_q;

  assign flags_in = '{negate: in_negate, sgn: in_signed, ext: in_extended,
                      modulus: in_modulus, word: in_word};

  idiv_ctrl #(.STEPS(DW)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .step(step), .fin(fin), .out_valid(out_valid)
  );

  idiv_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .load(load), .step(step), .fin(fin),
    .dividend(in_dividend), .divisor(in_divisor), .flags_in(flags_in),
    .quo(quo), .rem(rem), .dvs_zero(dvs_zero), .pre_ovf(pre_ovf),
    .flags_q(flags_q)
  );

  idiv_fixup #(.DW(DW)) u_fix (
    .quo(quo), .rem(rem), .dvs_zero(dvs_zero), .pre_ovf(pre_ovf),
    .flags(flags_q), .result(fix_res)
  );

  always_ff @(posedge clk) begin
    if (rst)      res_q <= '0;
    else if (fin) res_q <= fix_res;
  end
  assign out_result = res_q;

  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(dvs_zero)) |-> (out_result == '0)); // R7
  AST_WORD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(flags_q.word && !flags_q.modulus)) |-> (out_result[DW-1:HW] == '0)); // R9
  AST_EXT_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(pre_ovf)) |-> (out_result == '0)); // R8
endmodule

// File: tb/tb_idiv64.sv
module tb_idiv64;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_dividend = '0, in_divisor = '0;
  logic        in_negate = 0, in_signed = 0, in_extended = 0, in_modulus = 0, in_word = 0;
  logic        out_valid;
  logic [63:0] out_result;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  idiv64 dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .in_negate(in_negate), .in_signed(in_signed), .in_extended(in_extended),
    .in_modulus(in_modulus), .in_word(in_word),
    .out_valid(out_valid), .out_result(out_result)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_div(input logic [63:0] d, input logic [63:0] v,
      input bit neg, input bit sg, input bit ext, input bit md, input bit wd);
    logic [127:0] n, dv, q, r, mx;
    logic [63:0]  res;
    int           w;
    if (wd) begin
      n  = ext ? {64'd0, d[31:0], 32'd0} : {96'd0, d[31:0]};
      dv = {96'd0, v[31:0]};
    end else begin
      n  = ext ? {d, 64'd0} : {64'd0, d};
      dv = {64'd0, v};
    end
    if (dv == 0) return 64'd0;
    q = n / dv;
    r = n % dv;
    if (!wd && ext && q[127:64] != 0) return 64'd0;
    if (md) return neg ? (64'd0 - r[63:0]) : r[63:0];
    w = wd ? 32 : 64;
    if (sg) mx = neg ? (128'd1 << (w - 1)) : ((128'd1 << (w - 1)) - 1);
    else    mx = (128'd1 << w) - 1;
    if (q > mx) return 64'd0;
    res = neg ? (64'd0 - q[63:0]) : q[63:0];
    if (wd) res[63:32] = 32'd0;
    return res;
  endfunction

  // Runs one operation; checks handshake (R2), latency and pulse (R3) and result.
  task automatic do_op(input logic [63:0] d, input logic [63:0] v, input bit neg, input bit sg,
      input bit ext, input bit md, input bit wd, input logic [63:0] exp, input string tag,
      input bit poke);
    int          got_k = -1;
    int          pulses = 0;
    logic [63:0] got = '0;
    @(negedge clk);
    in_dividend = d; in_divisor = v; in_negate = neg; in_signed = sg;
    in_extended = ext; in_modulus = md; in_word = wd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R2 ready low while busy", {63'd0, in_ready}, 64'd0);
    for (int k = 2; k <= 70; k++) begin
      @(negedge clk);
      if (poke && k == 10) begin
        in_dividend = 64'h1234_5678_9abc_def0; in_divisor = 64'd3;
        in_negate = 1'b1; in_modulus = ~md; in_valid = 1'b1;
      end
      if (poke && k == 12) in_valid = 1'b0;
      if (out_valid) begin
        pulses++;
        if (got_k < 0) begin got_k = k; got = out_result; end
      end
    end
    chk(got_k == 66, "R3 latency", 64'(got_k), 64'd66);
    chk(pulses == 1, "R3 single pulse", 64'(pulses), 64'd1);
    chk(got == exp, tag, got, exp);
  endtask

  function automatic logic [63:0] rnd_bytes(input int len);
    logic [63:0] x;
    x = {$urandom, $urandom};
    if (len < 8) x = x & ((64'd1 << (8 * len)) - 1);
    return x;
  endfunction

  function automatic logic [63:0] sext(input logic [63:0] x, input int len);
    int sh;
    sh = 64 - 8 * len;
    return 64'($signed(x << sh) >>> sh);
  endfunction

  task automatic rand_op();
    logic [63:0] a, b, dm, vm;
    bit sg, ext, md, wd, neg;
    int la, lb, maxl;
    string tag;
    sg = $urandom % 2; ext = $urandom % 2; md = $urandom % 2; wd = $urandom % 2;
    maxl = wd ? 4 : 8;
    la = 1 + $urandom % maxl;
    lb = 1 + $urandom % maxl;
    if (ext && la > lb) begin int t = la; la = lb; lb = t; end
    if (!ext && lb > la) begin int t = la; la = lb; lb = t; end
    a = rnd_bytes(la);
    b = rnd_bytes(lb);
    if ($urandom % 20 == 0) b = 64'd0;
    if (sg) begin
      a = sext(a, la); b = sext(b, lb);
      if (wd && la == 4) a = sext(a, 4);
      dm  = a[63] ? (64'd0 - a) : a;
      vm  = b[63] ? (64'd0 - b) : b;
      neg = md ? a[63] : (a[63] ^ b[63]);
    end else begin
      dm = a; vm = b; neg = 1'b0;
    end
    tag = $sformatf("%s random sg=%0d ext=%0d mod=%0d word=%0d d=%h v=%h",
                    md ? (wd ? "R6 R11" : "R6") : (wd ? (ext ? "R10" : "R9") : (ext ? "R8" : (sg ? "R5" : "R4"))),
                    sg, ext, md, wd, dm, vm);
    do_op(dm, vm, neg, sg, ext, md, wd, ref_div(dm, vm, neg, sg, ext, md, wd), tag, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", {63'd0, out_valid}, 64'd0);
    chk(out_result == 64'd0, "R1 reset result", out_result, 64'd0);
    chk(in_ready == 1'b1, "R1 reset ready", {63'd0, in_ready}, 64'd1);

    // R4 directed, with a start poked while busy (R2)
    do_op(64'h10001000, 64'h1111, 0, 0, 0, 0, 0, 64'hF001, "R4 R2 directed quotient", 1'b1);
    // R7 zero divisor in several modes
    do_op(64'd77, 64'd0, 0, 0, 0, 0, 0, 64'd0, "R7 zero divisor quotient", 1'b0);
    do_op(64'd77, 64'd0, 1, 1, 0, 1, 0, 64'd0, "R7 zero divisor remainder", 1'b0);
    do_op(64'd0, 64'd0, 0, 0, 1, 0, 0, 64'd0, "R7 zero divisor extended", 1'b0);
    do_op(64'd5, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, 0, 1, 64'd0, "R7 zero divisor word low half", 1'b0);
    // R5 signed range and negation
    do_op(64'h8000_0000_0000_0000, 64'd1, 0, 1, 0, 0, 0, 64'd0, "R5 signed overflow", 1'b0);
    do_op(64'h8000_0000_0000_0000, 64'd1, 1, 1, 0, 0, 0, 64'h8000_0000_0000_0000, "R5 most negative", 1'b0);
    do_op(64'd100, 64'd7, 1, 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF2, "R5 negated quotient", 1'b0);
    // R6 / R11 remainder
    do_op(64'd100, 64'd7, 1, 1, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFE, "R6 negated remainder", 1'b0);
    do_op(64'd100, 64'd7, 1, 1, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFE, "R11 word remainder sign-extended", 1'b0);
    // R8 64-bit extended
    do_op(64'd1, 64'd3, 0, 0, 1, 0, 0, 64'h5555_5555_5555_5555, "R8 extended quotient", 1'b0);
    do_op(64'd5, 64'd5, 0, 0, 1, 0, 0, 64'd0, "R8 extended dividend>=divisor", 1'b0);
    do_op(64'd5, 64'd5, 0, 0, 1, 1, 0, 64'd0, "R8 extended remainder overflow", 1'b0);
    do_op(64'd1, 64'd2, 0, 1, 1, 0, 0, 64'd0, "R8 signed extended overflow", 1'b0);
    do_op(64'd1, 64'd2, 1, 1, 1, 0, 0, 64'h8000_0000_0000_0000, "R8 signed extended limit", 1'b0);
    // R9 word mode
    do_op(64'hFFFF_FFFF_0000_0007, 64'hAAAA_0000_0000_0002, 0, 0, 0, 0, 1, 64'd3, "R9 word ignores upper bits", 1'b0);
    do_op(64'd100, 64'd7, 1, 1, 0, 0, 1, 64'h0000_0000_FFFF_FFF2, "R9 word negated quotient upper clear", 1'b0);
    do_op(64'h8000_0000, 64'd1, 0, 1, 0, 0, 1, 64'd0, "R9 word signed overflow", 1'b0);
    // R10 word extended
    do_op(64'd1, 64'd3, 0, 0, 1, 0, 1, 64'h5555_5555, "R10 word extended quotient", 1'b0);
    do_op(64'd3, 64'd3, 0, 0, 1, 0, 1, 64'd0, "R10 word extended overflow", 1'b0);
    do_op(64'd1, 64'd2, 1, 1, 1, 0, 1, 64'h8000_0000, "R10 word signed extended limit", 1'b0);

    for (int i = 0; i < 400; i++) rand_op();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule